// File: doc/BRIEF.md
# Link-Layer Bring-Up Controller

This block sequences the data link layer of a serial interconnect port from the physical layer's link-up indication to normal operation. It holds the link layer idle while the physical link is down. When the link comes up it optionally runs a feature-exchange phase, then a two-step flow-control initialization for the default virtual channel, and finally enters normal operation, where transaction packets may flow.

The controller produces the link-layer up/down status and the enables that gate link-layer packet transmission, link-layer packet reception and transaction packet traffic. Whenever the physical link drops, the controller leaves any state at once. On its first cycle back in the idle state it gives a single-cycle pulse that flushes the replay storage and another that discards outstanding transactions. Packet contents, replay, acknowledgement and power management belong to other blocks.

States, with the code shown on `state_o`: IDLE (0, link down), FEAT (1, feature exchange), FC1 (2, first flow-control step), FC2 (3, second flow-control step), RUN (4, normal operation). Transitions: IDLE→FEAT (link up, exchange enabled), IDLE→FC1 (link up, exchange disabled), FEAT→FC1 (exchange done), FC1→FC2 (first step done), FC2→RUN (second step done), and any state→IDLE (link down).

Top module: `dl_bringup_ctrl`

## Requirements
- R1: After reset the state is IDLE (code 0), `dl_down_o`=1, `dl_up_o`=0, every enable is 0 and neither pulse is asserted.
- R2: When `phy_link_up_i` is 0 at a clock edge, the state is IDLE (code 0) in the following cycle, whatever the state was before.
- R3: `flush_replay_o` and `drop_pending_o` are both 1 for exactly the first cycle of IDLE that follows any other state. They are 0 at all other times, including the cycles after reset.
- R4: In IDLE with `phy_link_up_i`=1, the next state is FEAT (code 1) if `feat_xchg_en_i`=1, and FC1 (code 2) otherwise.
- R5: In FEAT, `dl_down_o`=1. The state moves to FC1 the cycle after `feat_done_i`=1 and otherwise stays in FEAT.
- R6: In FC1, `dl_down_o`=1, and the state moves to FC2 (code 3) the cycle after `fc1_done_i`=1. In FC2, `dl_up_o`=1.
- R7: In FC2, `fc2_done_i`=1 moves the state to RUN (code 4). RUN holds while the link is up, and `dl_up_o`=1 there.
- R8: `tlp_en_o` is 1 only in RUN. `dllp_tx_en_o` and `dllp_rx_en_o` are 1 in every state except IDLE.
- R9: A completion input has no effect outside its own state. For example, `fc2_done_i` in FC1 does not skip FC2, and `fc1_done_i` in FEAT does not skip FC1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| phy_link_up_i | input | 1 | Physical layer reports the link as operational |
| feat_xchg_en_i | input | 1 | Run the feature-exchange phase on bring-up |
| feat_done_i | input | 1 | Feature exchange finished |
| fc1_done_i | input | 1 | First flow-control initialization step finished |
| fc2_done_i | input | 1 | Second flow-control initialization step finished |
| state_o | output | 3 | Current state code |
| dl_up_o | output | 1 | Link layer reported up |
| dl_down_o | output | 1 | Link layer reported down |
| flush_replay_o | output | 1 | One-cycle replay storage flush |
| drop_pending_o | output | 1 | One-cycle discard of outstanding transactions |
| dllp_tx_en_o | output | 1 | Link-layer packet transmission allowed |
| dllp_rx_en_o | output | 1 | Link-layer packet reception allowed |
| tlp_en_o | output | 1 | Transaction packet traffic allowed |

## Verification
The assertions check four things on every cycle: the drop to IDLE after link loss, the single-cycle shape of the flush and discard pulses and their tie to an IDLE entry, the rise of the up status only out of FC1, and the gating of the enables by state. Other behaviour can only be shown by the bench's scenarios: whether the optional feature phase is taken or skipped, that a completion input arriving out of order is ignored, and that no pulse follows reset. A reference model in the bench tracks the state under random and directed inputs for these.

// File: rtl/dl_bringup_pkg.sv
package dl_bringup_pkg;

    localparam int unsigned ST_W = 3;

    typedef enum logic [ST_W-1:0] {
        ST_IDLE = 3'd0,
        ST_FEAT = 3'd1,
        ST_FC1  = 3'd2,
        ST_FC2  = 3'd3,
        ST_RUN  = 3'd4
    } dl_state_e;

    typedef struct packed {
        logic up;
        logic dllp_tx;
        logic dllp_rx;
        logic tlp;
    } dl_status_t;

endpackage

// File: rtl/dl_bringup_next.sv
module dl_bringup_next
    import dl_bringup_pkg::*;
(
    input  dl_state_e cur_i,
    input  logic      link_up_i,
    input  logic      feat_en_i,
    input  logic      feat_done_i,
    input  logic      fc1_done_i,
    input  logic      fc2_done_i,
    output dl_state_e nxt_o
);

    always_comb begin
        nxt_o = cur_i;
        if (!link_up_i) begin
            nxt_o = ST_IDLE;
        end else begin
            unique case (cur_i)
                ST_IDLE: nxt_o = feat_en_i ? ST_FEAT : ST_FC1;
                ST_FEAT: if (feat_done_i) nxt_o = ST_FC1;
                ST_FC1:  if (fc1_done_i)  nxt_o = ST_FC2;
                ST_FC2:  if (fc2_done_i)  nxt_o = ST_RUN;
                ST_RUN:  nxt_o = ST_RUN;
                default: nxt_o = ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/dl_bringup_decode.sv
module dl_bringup_decode
    import dl_bringup_pkg::*;
(
    input  dl_state_e  cur_i,
    output dl_status_t stat_o
);

    always_comb begin
        stat_o = '0;
        unique case (cur_i)
            ST_IDLE: stat_o = '0;
            ST_FEAT: begin
                stat_o.dllp_tx = 1'b1;
                stat_o.dllp_rx = 1'b1;
            end
            ST_FC1: begin
                stat_o.dllp_tx = 1'b1;
                stat_o.dllp_rx = 1'b1;
            end
            ST_FC2: begin
                stat_o.up      = 1'b1;
                stat_o.dllp_tx = 1'b1;
                stat_o.dllp_rx = 1'b1;
            end
            ST_RUN: begin
                stat_o.up      = 1'b1;
                stat_o.dllp_tx = 1'b1;
                stat_o.dllp_rx = 1'b1;
                stat_o.tlp     = 1'b1;
            end
            default: stat_o = '0;
        endcase
    end

endmodule

// File: rtl/dl_bringup_entry.sv
module dl_bringup_entry
    import dl_bringup_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  dl_state_e cur_i,
    output logic      entry_o
);

    logic was_idle_q;

    always_ff @(posedge clk) begin
        if (!rst_n) was_idle_q <= 1'b1;
        else        was_idle_q <= (cur_i == ST_IDLE);
    end

    assign entry_o = (cur_i == ST_IDLE) && !was_idle_q;

endmodule

// File: rtl/dl_bringup_ctrl.sv
module dl_bringup_ctrl
    import dl_bringup_pkg::*;
#(
    parameter bit HAS_FEATURE = 1'b1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            phy_link_up_i,
    input  logic            feat_xchg_en_i,
    input  logic            feat_done_i,
    input  logic            fc1_done_i,
    input  logic            fc2_done_i,
    output logic [ST_W-1:0] state_o,
    output logic            dl_up_o,
    output logic            dl_down_o,
    output logic            flush_replay_o,
    output logic            drop_pending_o,
    output logic            dllp_tx_en_o,
    output logic            dllp_rx_en_o,
    output logic            tlp_en_o
);

    dl_state_e  state_q;
    dl_state_e  state_d;
    dl_status_t stat;
    logic       feat_en;
    logic       entry;

    generate
        if (HAS_FEATURE) begin : g_feat
            assign feat_en = feat_xchg_en_i;
        end else begin : g_nofeat
            assign feat_en = 1'b0;
        end
    endgenerate

    dl_bringup_next u_next (
        .cur_i       (state_q),
        .link_up_i   (phy_link_up_i),
        .feat_en_i   (feat_en),
        .feat_done_i (feat_done_i),
        .fc1_done_i  (fc1_done_i),
        .fc2_done_i  (fc2_done_i),
        .nxt_o       (state_d)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    dl_bringup_decode u_dec (
        .cur_i  (state_q),
        .stat_o (stat)
    );

    dl_bringup_entry u_entry (
        .clk     (clk),
        .rst_n   (rst_n),
        .cur_i   (state_q),
        .entry_o (entry)
    );

    always_comb begin
        state_o        = state_q;
        dl_up_o        = stat.up;
        dl_down_o      = !stat.up;
        dllp_tx_en_o   = stat.dllp_tx;
        dllp_rx_en_o   = stat.dllp_rx;
        tlp_en_o       = stat.tlp;
        flush_replay_o = entry;
        drop_pending_o = entry;
    end

endmodule

// File: rtl/dl_bringup_checker.sv
module dl_bringup_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       phy_link_up_i,
    input logic [2:0] state_o,
    input logic       dl_up_o,
    input logic       flush_replay_o,
    input logic       drop_pending_o,
    input logic       dllp_tx_en_o,
    input logic       dllp_rx_en_o,
    input logic       tlp_en_o
);

    a_r2_drop_to_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !phy_link_up_i |=> state_o == 3'd0);

    a_r3_flush_single: assert property (@(posedge clk) disable iff (!rst_n)
        flush_replay_o |=> !flush_replay_o);

    a_r3_drop_single: assert property (@(posedge clk) disable iff (!rst_n)
        drop_pending_o |=> !drop_pending_o);

    a_r3_pulse_on_entry: assert property (@(posedge clk) disable iff (!rst_n)
        flush_replay_o |-> (state_o == 3'd0 && $past(state_o) != 3'd0));

    a_r6_up_from_fc1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dl_up_o) |-> $past(state_o) == 3'd2);

    a_r8_tlp_gated: assert property (@(posedge clk) disable iff (!rst_n)
        tlp_en_o |-> (dl_up_o && dllp_tx_en_o));

    a_r8_idle_silent: assert property (@(posedge clk) disable iff (!rst_n)
        state_o == 3'd0 |-> (!dllp_tx_en_o && !dllp_rx_en_o && !tlp_en_o));

endmodule

bind dl_bringup_ctrl dl_bringup_checker u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .phy_link_up_i  (phy_link_up_i),
    .state_o        (state_o),
    .dl_up_o        (dl_up_o),
    .flush_replay_o (flush_replay_o),
    .drop_pending_o (drop_pending_o),
    .dllp_tx_en_o   (dllp_tx_en_o),
    .dllp_rx_en_o   (dllp_rx_en_o),
    .tlp_en_o       (tlp_en_o)
);

// File: tb/test_dl_bringup_ctrl.sv
module test_dl_bringup_ctrl;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       lu = 1'b0, fe = 1'b0, fd = 1'b0, f1 = 1'b0, f2 = 1'b0;
    logic [2:0] state_o;
    logic       dl_up_o, dl_down_o, flush_o, drop_o, dtx_o, drx_o, tlp_o;

    int unsigned n_chk = 0;
    int unsigned n_bad = 0;
    bit          done_flag = 1'b0;

    int unsigned m_st = 0;
    bit          m_pulse = 1'b0;

    always #5ns clk = ~clk;

    dl_bringup_ctrl i_dl_bringup_ctrl (
        .clk            (clk),
        .rst_n          (rst_n),
        .phy_link_up_i  (lu),
        .feat_xchg_en_i (fe),
        .feat_done_i    (fd),
        .fc1_done_i     (f1),
        .fc2_done_i     (f2),
        .state_o        (state_o),
        .dl_up_o        (dl_up_o),
        .dl_down_o      (dl_down_o),
        .flush_replay_o (flush_o),
        .drop_pending_o (drop_o),
        .dllp_tx_en_o   (dtx_o),
        .dllp_rx_en_o   (drx_o),
        .tlp_en_o       (tlp_o)
    );

    function automatic int unsigned model_next(int unsigned s, bit l, bit e,
                                               bit d, bit a, bit b);
        if (!l) return 0;
        case (s)
            0: return e ? 1 : 2;
            1: return d ? 2 : 1;
            2: return a ? 3 : 2;
            3: return b ? 4 : 3;
            default: return 4;
        endcase
    endfunction

    function automatic bit model_up(int unsigned s);
        return (s == 3) || (s == 4);
    endfunction

    task automatic chk(string tag, int unsigned act, int unsigned exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic compare(string tag);
        chk({tag, " state"},   state_o, m_st);
        chk({tag, " dl_up"},   dl_up_o, model_up(m_st));
        chk({tag, " dl_down"}, dl_down_o, !model_up(m_st));
        chk({tag, " flush R3"}, flush_o, m_pulse);
        chk({tag, " drop R3"},  drop_o, m_pulse);
        chk({tag, " dllp_tx R8"}, dtx_o, m_st != 0);
        chk({tag, " dllp_rx R8"}, drx_o, m_st != 0);
        chk({tag, " tlp R8"},   tlp_o, m_st == 4);
    endtask

    task automatic apply(bit l, bit e, bit d, bit a, bit b);
        int unsigned nx;
        lu = l; fe = e; fd = d; f1 = a; f2 = b;
        @(posedge clk);
        nx = model_next(m_st, l, e, d, a, b);
        m_pulse = (nx == 0) && (m_st != 0);
        m_st = nx;
        @(negedge clk);
    endtask

    initial begin
        #2ms;
        if (!done_flag) begin
            n_bad++;
            $display("FAIL watchdog: actual 1 expected 0");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        int unsigned seed;
        seed = 32'h5eed_1234;
        void'($urandom(seed));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        compare("R1 reset");
        apply(0, 0, 0, 0, 0); compare("R1 idle hold no pulse");

        // feature path
        apply(1, 1, 0, 0, 0); compare("R4 to FEAT");
        apply(1, 1, 0, 1, 1); compare("R9 FEAT ignores fc dones");
        chk("R5 FEAT down", dl_down_o, 1);
        apply(1, 1, 1, 0, 0); compare("R5 FEAT to FC1");
        apply(1, 0, 1, 0, 1); compare("R9 FC1 ignores fc2 done");
        chk("R6 FC1 down", dl_down_o, 1);
        apply(1, 0, 0, 1, 0); compare("R6 FC1 to FC2");
        chk("R6 FC2 up", dl_up_o, 1);
        apply(1, 0, 0, 0, 1); compare("R7 FC2 to RUN");
        apply(1, 0, 0, 0, 0); compare("R7 RUN holds");
        chk("R8 tlp in RUN", tlp_o, 1);
        apply(0, 0, 0, 0, 0); compare("R2 RUN drop");
        chk("R3 pulse on entry", flush_o, 1);
        apply(0, 0, 0, 0, 0); compare("R3 pulse ends");
        chk("R3 single cycle", flush_o, 0);

        // direct path without feature exchange
        apply(1, 0, 0, 0, 0); compare("R4 to FC1");
        chk("R4 skipped FEAT", state_o, 2);
        apply(1, 0, 0, 1, 0); compare("R6 to FC2");
        apply(0, 0, 0, 0, 0); compare("R2 FC2 drop");

        // random
        for (int i = 0; i < 3000; i++) begin
            bit l, e, d, a, b;
            l = ($urandom % 16) != 0;
            e = $urandom % 2;
            d = ($urandom % 3) == 0;
            a = ($urandom % 3) == 0;
            b = ($urandom % 3) == 0;
            apply(l, e, d, a, b);
            compare("R2-model random");
        end

        done_flag = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule